// File: doc/BRIEF.md
# Single-Precision Classify, Sign-Inject and Register-Move Unit

This combinational unit carries out the single-precision floating-point operations that involve no arithmetic. It can classify an operand into one of ten categories and return a one-hot mask. It can build a new value from the magnitude of one operand and a sign taken from a second operand. It can also copy raw bit patterns between a float register and an integer register. The integer register width and the float register width are both parameters. When the float register is wider than 32 bits, every float result is NaN-boxed. A value copied into the integer side is sign-extended from bit 31.

An execution stage drives the two 32-bit operands, the integer-register value and a 3-bit operation code. It picks up the result from either the float or the integer output in the same cycle. Because none of these operations round or raise exceptions, the flag output is constant zero. It exists only so the unit can sit beside the arithmetic units behind a common result interface.

Top module: `fp_misc_unit`

## Requirements
- R1: An operand is split into sign (bit 31), exponent (bits 30:23) and fraction (bits 22:0). For a classify operation (op_code 0), int_res sets exactly one bit, chosen by sign and category. Mask bit 0 is negative infinity, 1 negative normal, 2 negative subnormal and 3 negative zero. Mask bit 4 is positive zero, 5 positive subnormal, 6 positive normal and 7 positive infinity. A subnormal has a zero exponent and a nonzero fraction. A normal has an exponent that is neither all zeros nor all ones.
- R2: Classify sets mask bit 8 for a signalling NaN and mask bit 9 for a quiet NaN, whatever the sign. A signalling NaN has an all-ones exponent, fraction bit 22 clear and a nonzero fraction. A quiet NaN has an all-ones exponent and fraction bit 22 set.
- R3: For classify, the 10-bit mask is zero-extended into int_res with exactly one bit set, and flt_res is zero.
- R4: op_code 1 (sign copy) returns bits 30:0 of opa with the sign of opb in bit 31, and int_res is zero.
- R5: op_code 2 (negated sign copy) returns bits 30:0 of opa with the inverse of opb's sign.
- R6: op_code 3 (sign xor) returns bits 30:0 of opa with the xor of the two signs.
- R7: With FLEN of 64, every float result has bits 63:32 all ones. With FLEN of 32, the float result is the 32-bit value alone.
- R8: op_code 4 (float to integer move) returns opa sign-extended from bit 31 to XLEN bits in int_res, and flt_res is zero.
- R9: op_code 5 (integer to float move) places int_val[31:0] in flt_res. int_val bits above 31 do not affect the result, and int_res is zero.
- R10: exc_flags is zero for every op_code and operand.
- R11: op_codes 6 and 7 are unused and drive both flt_res and int_res to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation: 0 classify, 1 sign copy, 2 negated sign copy, 3 sign xor, 4 float to integer move, 5 integer to float move |
| opa | input | 32 | First single-precision operand (magnitude source, classify and move source) |
| opb | input | 32 | Second single-precision operand (sign source) |
| int_val | input | XLEN | Integer-register value for the integer to float move |
| flt_res | output | FLEN | Float-register result, NaN-boxed when FLEN is 64 |
| int_res | output | XLEN | Integer-register result |
| exc_flags | output | 5 | Exception flags, always zero for these operations |

## Verification
Uniformly random 32-bit words almost never produce an all-zeros exponent, an infinity, or a NaN with a specific value of fraction bit 22. Random operands alone would therefore leave subnormals, zeros and the signalling/quiet distinction nearly untested. The stimulus generator therefore forces the exponent to all zeros or all ones in most draws and often clears the fraction. It also sets fraction bit 22 independently, so the signalling NaN, the quiet NaN and the infinity encodings each come up for both signs. Directed vectors add the one-fraction-bit signalling NaN and the smallest subnormal, which are the boundary patterns. They also add integer inputs whose upper half is nonzero, to show that the move ignores those bits.

// File: rtl/fpmu_pkg.sv
package fpmu_pkg;
  localparam int SP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int CLASS_W = 10;
  localparam int FLAG_W  = 5;

  typedef enum logic [2:0] {
    OP_CLASS = 3'd0,
    OP_SGNJ  = 3'd1,
    OP_SGNJN = 3'd2,
    OP_SGNJX = 3'd3,
    OP_F2I   = 3'd4,
    OP_I2F   = 3'd5
  } fpmu_op_e;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } sp_t;

  // mask bit positions
  localparam int CL_NINF  = 0;
  localparam int CL_NNORM = 1;
  localparam int CL_NSUB  = 2;
  localparam int CL_NZERO = 3;
  localparam int CL_PZERO = 4;
  localparam int CL_PSUB  = 5;
  localparam int CL_PNORM = 6;
  localparam int CL_PINF  = 7;
  localparam int CL_SNAN  = 8;
  localparam int CL_QNAN  = 9;
endpackage

// File: rtl/fpmu_classifier.sv
module fpmu_classifier
  import fpmu_pkg::*;
(
  input  sp_t                val,
  output logic [CLASS_W-1:0] mask
);
  logic exp_ones, exp_zero, man_zero, quiet_bit;
  logic is_nan, is_inf, is_sub, is_zero, is_norm;

  always_comb begin
    exp_ones  = &val.exp;
    exp_zero  = ~|val.exp;
    man_zero  = ~|val.man;
    quiet_bit = val.man[MAN_W-1];
    is_nan    = exp_ones & ~man_zero;
    is_inf    = exp_ones & man_zero;
    is_sub    = exp_zero & ~man_zero;
    is_zero   = exp_zero & man_zero;
    is_norm   = ~exp_ones & ~exp_zero;

    mask           = '0;
    mask[CL_NINF]  = val.sgn  & is_inf;
    mask[CL_NNORM] = val.sgn  & is_norm;
    mask[CL_NSUB]  = val.sgn  & is_sub;
    mask[CL_NZERO] = val.sgn  & is_zero;
    mask[CL_PZERO] = ~val.sgn & is_zero;
    mask[CL_PSUB]  = ~val.sgn & is_sub;
    mask[CL_PNORM] = ~val.sgn & is_norm;
    mask[CL_PINF]  = ~val.sgn & is_inf;
    mask[CL_SNAN]  = is_nan & ~quiet_bit;
    mask[CL_QNAN]  = is_nan & quiet_bit;
  end
endmodule

// File: rtl/fpmu_sign_inject.sv
module fpmu_sign_inject
  import fpmu_pkg::*;
(
  input  fpmu_op_e op,
  input  sp_t      mag_src,
  input  sp_t      sgn_src,
  output sp_t      y
);
  logic new_sgn;

  always_comb begin
    unique case (op)
      OP_SGNJN: new_sgn = ~sgn_src.sgn;
      OP_SGNJX: new_sgn = mag_src.sgn ^ sgn_src.sgn;
      default:  new_sgn = sgn_src.sgn;
    endcase
    y     = mag_src;
    y.sgn = new_sgn;
  end
endmodule

// File: rtl/fpmu_nan_box.sv
module fpmu_nan_box
  import fpmu_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [SP_W-1:0] sp_in,
  output logic [FLEN-1:0] boxed
);
  localparam int PAD_W = FLEN - SP_W;

  generate
    if (PAD_W > 0) begin : g_box
      assign boxed = {{PAD_W{1'b1}}, sp_in};
    end else begin : g_plain
      assign boxed = sp_in;
    end
  endgenerate
endmodule

// File: rtl/fpmu_sext.sv
module fpmu_sext
  import fpmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [SP_W-1:0] word_in,
  output logic [XLEN-1:0] wide_out
);
  localparam int EXT_W = XLEN - SP_W;

  generate
    if (EXT_W > 0) begin : g_ext
      assign wide_out = {{EXT_W{word_in[SP_W-1]}}, word_in};
    end else begin : g_same
      assign wide_out = word_in;
    end
  endgenerate
endmodule

// File: rtl/fp_misc_unit.sv
module fp_misc_unit
  import fpmu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int FLEN = 64
) (
  input  logic [2:0]        op_code,
  input  logic [31:0]       opa,
  input  logic [31:0]       opb,
  input  logic [XLEN-1:0]   int_val,
  output logic [FLEN-1:0]   flt_res,
  output logic [XLEN-1:0]   int_res,
  output logic [4:0]        exc_flags
);
  localparam int MASK_PAD = XLEN - CLASS_W;

  fpmu_op_e           op;
  logic [CLASS_W-1:0] class_mask;
  sp_t                inj_val;
  logic [SP_W-1:0]    flt_pick;
  logic [FLEN-1:0]    flt_boxed;
  logic [XLEN-1:0]    moved_int;
  logic               flt_sel;

  assign op = fpmu_op_e'(op_code);

  fpmu_classifier u_class (
    .val  (sp_t'(opa)),
    .mask (class_mask)
  );

  fpmu_sign_inject u_sinj (
    .op      (op),
    .mag_src (sp_t'(opa)),
    .sgn_src (sp_t'(opb)),
    .y       (inj_val)
  );

  fpmu_nan_box #(.FLEN(FLEN)) u_box (
    .sp_in (flt_pick),
    .boxed (flt_boxed)
  );

  fpmu_sext #(.XLEN(XLEN)) u_sext (
    .word_in  (opa),
    .wide_out (moved_int)
  );

  always_comb begin
    flt_pick = '0;
    flt_sel  = 1'b0;
    int_res  = '0;
    case (op)
      OP_CLASS: int_res = {{MASK_PAD{1'b0}}, class_mask};
      OP_SGNJ, OP_SGNJN, OP_SGNJX: begin
        flt_pick = inj_val;
        flt_sel  = 1'b1;
      end
      OP_F2I:   int_res = moved_int;
      OP_I2F: begin
        flt_pick = int_val[SP_W-1:0];
        flt_sel  = 1'b1;
      end
      default: ;
    endcase
  end

  assign flt_res   = flt_sel ? flt_boxed : '0;
  assign exc_flags = '0;
endmodule

// File: rtl/fpmu_chk.sv
module fpmu_chk #(
  parameter int XLEN = 64,
  parameter int FLEN = 64
) (
  input logic [2:0]      op_code,
  input logic [31:0]     opa,
  input logic [31:0]     opb,
  input logic [XLEN-1:0] int_val,
  input logic [FLEN-1:0] flt_res,
  input logic [XLEN-1:0] int_res,
  input logic [4:0]      exc_flags
);
  logic flt_op;
  assign flt_op = (op_code >= 3'd1 && op_code <= 3'd3) || op_code == 3'd5;

  always_comb begin
    // R3
    class_onehot_chk: assert (op_code != 3'd0 ||
                              ($onehot(int_res[9:0]) && (int_res >> 10) == '0 && flt_res == '0))
      else $error("class mask not one-hot or not zero-extended");
    // R2
    nan_class_chk: assert (op_code != 3'd0 || !(&opa[30:23] && |opa[22:0]) || int_res[9:8] != 2'b00)
      else $error("NaN operand not classified as NaN");
    // R4
    sgnj_mag_chk: assert (!(op_code >= 3'd1 && op_code <= 3'd3) ||
                          (flt_res[30:0] == opa[30:0] && int_res == '0))
      else $error("sign injection changed magnitude");
    // R4
    sgnj_sign_chk: assert (op_code != 3'd1 || flt_res[31] == opb[31])
      else $error("sign copy took wrong sign");
    // R10
    flags_zero_chk: assert (exc_flags == 5'd0)
      else $error("flags raised");
    // R11
    undef_zero_chk: assert (op_code < 3'd6 || (flt_res == '0 && int_res == '0))
      else $error("unused op drove a result");
    // R9
    i2f_low_chk: assert (op_code != 3'd5 || (flt_res[31:0] == int_val[31:0] && int_res == '0))
      else $error("integer to float move wrong");
  end

  generate
    if (FLEN > 32) begin : g_box_chk
      always_comb begin
        // R7
        nan_box_chk: assert (!flt_op || &flt_res[FLEN-1:32])
          else $error("float result not NaN-boxed");
      end
    end
    if (XLEN > 32) begin : g_sext_chk
      always_comb begin
        // R8
        sext_chk: assert (op_code != 3'd4 ||
                          (int_res[31:0] == opa && int_res[XLEN-1:32] == {(XLEN-32){opa[31]}}))
          else $error("float to integer move not sign-extended");
      end
    end
  endgenerate
endmodule

bind fp_misc_unit fpmu_chk #(.XLEN(XLEN), .FLEN(FLEN)) u_chk (.*);

// File: tb/sim_fp_misc_unit.sv
module sim_fp_misc_unit;
  localparam int XLEN = 64;
  localparam int FLEN = 64;

  logic            clk;
  logic            rst_n;
  logic [2:0]      op_code;
  logic [31:0]     opa, opb;
  logic [XLEN-1:0] int_val;
  logic [FLEN-1:0] flt_res;
  logic [XLEN-1:0] int_res;
  logic [4:0]      exc_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fp_misc_unit #(.XLEN(XLEN), .FLEN(FLEN)) u0 (
    .op_code(op_code), .opa(opa), .opb(opb), .int_val(int_val),
    .flt_res(flt_res), .int_res(int_res), .exc_flags(exc_flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [9:0] ref_class(input logic [31:0] v);
    logic s; logic [7:0] e; logic [22:0] m;
    s = v[31]; e = v[30:23]; m = v[22:0];
    if (e == 8'hFF) begin
      if (m == 0) return s ? 10'd1 : 10'd128;
      return m[22] ? 10'd512 : 10'd256;
    end
    if (e == 8'h00) begin
      if (m == 0) return s ? 10'd8 : 10'd16;
      return s ? 10'd4 : 10'd32;
    end
    return s ? 10'd2 : 10'd64;
  endfunction

  function automatic logic [63:0] ref_box(input logic [31:0] v);
    return {32'hFFFF_FFFF, v};
  endfunction

  function automatic logic [63:0] ref_sext(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [31:0] gen_sp();
    logic [31:0] r;
    int sel;
    r = $urandom;
    sel = $urandom % 5;
    if (sel == 0) r[30:23] = 8'h00;
    else if (sel <= 2) r[30:23] = 8'hFF;
    if ($urandom % 3 == 0) r[21:0] = '0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [63:0] iv);
    logic [63:0] ef, ei;
    string tag;
    @(negedge clk);
    op_code = op; opa = a; opb = b; int_val = iv;
    #2;
    ef = '0; ei = '0;
    case (op)
      3'd0: begin
        ei = {54'd0, ref_class(a)};
        tag = (a[30:23] == 8'hFF && a[22:0] != 0) ? "R2 R3" : "R1 R3";
      end
      3'd1: begin ef = ref_box({b[31], a[30:0]});         tag = "R4 R7"; end
      3'd2: begin ef = ref_box({~b[31], a[30:0]});        tag = "R5 R7"; end
      3'd3: begin ef = ref_box({a[31] ^ b[31], a[30:0]}); tag = "R6 R7"; end
      3'd4: begin ei = ref_sext(a);                       tag = "R8"; end
      3'd5: begin ef = ref_box(iv[31:0]);                 tag = "R9 R7"; end
      default: tag = "R11";
    endcase
    chk({tag, " int"}, int_res, ei);
    chk({tag, " flt"}, flt_res, ef);
    chk("R10 flags", {59'd0, exc_flags}, 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    op_code = 3'd0; opa = '0; opb = '0; int_val = '0;
    repeat (2) @(posedge clk);
    #2;
    // initial state: classify of +0
    chk("R3 initial", int_res, 64'd16);
    rst_n = 1'b1;

    // R1 categories, both signs
    run(3'd0, 32'h0000_0000, 0, 0);
    run(3'd0, 32'h8000_0000, 0, 0);
    run(3'd0, 32'h0000_0001, 0, 0);
    run(3'd0, 32'h8040_0000, 0, 0);
    run(3'd0, 32'h3F80_0000, 0, 0);
    run(3'd0, 32'hFF7F_FFFF, 0, 0);
    run(3'd0, 32'h7F80_0000, 0, 0);
    run(3'd0, 32'hFF80_0000, 0, 0);
    // R2 NaNs, sign ignored
    run(3'd0, 32'h7F80_0001, 0, 0);
    run(3'd0, 32'hFFBF_FFFF, 0, 0);
    run(3'd0, 32'h7FC0_0000, 0, 0);
    run(3'd0, 32'hFFC0_0000, 0, 0);
    // R4 R5 R6
    run(3'd1, 32'h3F80_0000, 32'h8000_0000, 0);
    run(3'd2, 32'h3F80_0000, 32'h8000_0000, 0);
    run(3'd3, 32'hBF80_0000, 32'h8000_0000, 0);
    run(3'd3, 32'hBF80_0000, 32'h0000_0000, 0);
    // R8
    run(3'd4, 32'h8000_0001, 0, 0);
    run(3'd4, 32'h7FFF_FFFF, 0, 0);
    // R9 upper int bits ignored
    run(3'd5, 0, 0, 64'hDEAD_BEEF_1234_5678);
    run(3'd5, 0, 0, 64'h0000_0000_1234_5678);
    // R11
    run(3'd6, 32'h7FC0_0000, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3'd7, 32'h3F80_0000, 32'h8000_0000, 64'h1);

    for (int i = 0; i < 400; i++) begin
      run(3'($urandom % 8), gen_sp(), gen_sp(), {$urandom, $urandom});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule